// File: doc/BRIEF.md
# Physical Register Ready Scoreboard

This block holds one ready bit for every entry of a unified physical register file. All register classes share a single flat index space. Rename logic clears a register's bit when it hands that register out as a destination. Writeback logic sets the bit again once the result exists. Issue logic asks through combinational lookup ports whether a source operand is available.

Each request carries two tags. A register tagged *fixed* is permanently mapped: lookups always report it ready, and writes to its bit are dropped. A register tagged *zero* can never be made not-ready, because a clear aimed at it is dropped.

A single-cycle error pulse reports two kinds of problem:
- an index beyond the configured register count;
- a zero-tagged lookup that finds its stored bit cleared.

A synchronous reset marks the whole file ready.

Top module: `preg_ready_board`

## Requirements
- R1: While `rst` is high at a rising edge, every ready bit is set at that edge, and `err` is low in the following cycle.
- R2: A valid set (`set_vld`) on an in-range, non-fixed index makes that register ready from the next rising edge. A valid clear (`clr_vld`) on an in-range index tagged neither fixed nor zero makes it not-ready from the next rising edge.
- R3: A lookup with `lk_fixed` high returns `lk_ready` = 1 in the same cycle, whatever the stored bit and index.
- R4: A set or clear with its fixed tag high leaves the stored bit unchanged.
- R5: A clear with `clr_zero` high leaves the stored bit unchanged.
- R6: When a set and a clear name the same index in the same cycle, the register is ready after the edge.
- R7: A non-fixed lookup whose index equals that of a qualifying set in the same cycle returns 1 before the edge, bypassing the stored bit.
- R8: Any valid lookup, set or clear whose index is ≥ `NUM_REGS` pulses `err` high in the next cycle. Such a request changes no bit. A non-fixed lookup of such an index returns 0.
- R9: A valid, non-fixed, in-range lookup with `lk_zero` high whose stored bit is 0 pulses `err` high in the next cycle.
- R10: In a cycle with no R8 or R9 violation, `err` is low in the next cycle.
- R11: All set ports and clear ports act in the same cycle, each on its own index, and each lookup port answers on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_vld | input | NUM_LOOKUP | Lookup valid, per port (gates error checks) |
| lk_idx | input | NUM_LOOKUP x IDX_W | Lookup flat index |
| lk_fixed | input | NUM_LOOKUP | Lookup target is fixed-mapped |
| lk_zero | input | NUM_LOOKUP | Lookup target is the zero register |
| lk_ready | output | NUM_LOOKUP | Combinational ready answer |
| set_vld | input | NUM_SET | Set-ready request valid |
| set_idx | input | NUM_SET x IDX_W | Set-ready index |
| set_fixed | input | NUM_SET | Set target is fixed-mapped |
| clr_vld | input | NUM_CLR | Clear-ready request valid |
| clr_idx | input | NUM_CLR x IDX_W | Clear-ready index |
| clr_fixed | input | NUM_CLR | Clear target is fixed-mapped |
| clr_zero | input | NUM_CLR | Clear target is the zero register |
| err | output | 1 | Registered one-cycle violation pulse |

## Verification
Writeback and rename can hit the same register in one cycle, and so can writeback and an issue-side lookup. Random stimulus confines most indices to a narrow window, so sets, clears and lookups often coincide. Directed cycles then force a set and a clear onto one index, and a lookup onto the index being set. A bench model judges each outcome: it applies clears first and sets after them, and it computes bypass answers from the set ports of the same cycle.

// File: rtl/preg_sb_pkg.sv
package preg_sb_pkg;

  // True when a flat index addresses an existing register.
  function automatic logic idx_in_range(input int unsigned idx, input int unsigned nregs);
    return idx < nregs;
  endfunction

  // A write request changes the array only if valid, in range and not fixed.
  function automatic logic write_qualifies(input logic vld, input logic fixed, input logic ok);
    return vld && ok && !fixed;
  endfunction

  // A clear additionally must not name the zero register.
  function automatic logic clear_qualifies(input logic vld, input logic fixed,
                                           input logic zero, input logic ok);
    return vld && ok && !fixed && !zero;
  endfunction

endpackage

// File: rtl/preg_sb_qual.sv
module preg_sb_qual
  import preg_sb_pkg::*;
#(
  parameter int NUM_REGS = 96,
  parameter int NUM_SET  = 2,
  parameter int NUM_CLR  = 1,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_SET-1:0]            set_vld,
  input  logic [NUM_SET-1:0][IDX_W-1:0] set_idx,
  input  logic [NUM_SET-1:0]            set_fixed,
  input  logic [NUM_CLR-1:0]            clr_vld,
  input  logic [NUM_CLR-1:0][IDX_W-1:0] clr_idx,
  input  logic [NUM_CLR-1:0]            clr_fixed,
  input  logic [NUM_CLR-1:0]            clr_zero,
  output logic [NUM_SET-1:0]            set_eff,
  output logic [NUM_CLR-1:0]            clr_eff,
  output logic [NUM_SET-1:0]            set_oor,
  output logic [NUM_CLR-1:0]            clr_oor
);
  for (genvar s = 0; s < NUM_SET; s++) begin : g_set
    logic ok;
    assign ok         = idx_in_range(int'(set_idx[s]), NUM_REGS);
    assign set_eff[s] = write_qualifies(set_vld[s], set_fixed[s], ok);
    assign set_oor[s] = set_vld[s] && !ok;
  end

  for (genvar c = 0; c < NUM_CLR; c++) begin : g_clr
    logic ok;
    assign ok         = idx_in_range(int'(clr_idx[c]), NUM_REGS);
    assign clr_eff[c] = clear_qualifies(clr_vld[c], clr_fixed[c], clr_zero[c], ok);
    assign clr_oor[c] = clr_vld[c] && !ok;
  end
endmodule

// File: rtl/preg_sb_array.sv
module preg_sb_array #(
  parameter int NUM_REGS = 96,
  parameter int NUM_SET  = 2,
  parameter int NUM_CLR  = 1,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SET-1:0]            set_eff,
  input  logic [NUM_SET-1:0][IDX_W-1:0] set_idx,
  input  logic [NUM_CLR-1:0]            clr_eff,
  input  logic [NUM_CLR-1:0][IDX_W-1:0] clr_idx,
  output logic [NUM_REGS-1:0]           ready_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    logic hit_set, hit_clr;
    always_comb begin
      hit_set = 1'b0;
      for (int s = 0; s < NUM_SET; s++)
        if (set_eff[s] && (int'(set_idx[s]) == g)) hit_set = 1'b1;
      hit_clr = 1'b0;
      for (int c = 0; c < NUM_CLR; c++)
        if (clr_eff[c] && (int'(clr_idx[c]) == g)) hit_clr = 1'b1;
    end
    // Set has priority over clear on the same register.
    always_ff @(posedge clk) begin
      if (rst)          ready_q[g] <= 1'b1;
      else if (hit_set) ready_q[g] <= 1'b1;
      else if (hit_clr) ready_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/preg_sb_lookup.sv
module preg_sb_lookup
  import preg_sb_pkg::*;
#(
  parameter int NUM_REGS = 96,
  parameter int NUM_SET  = 2,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                          vld,
  input  logic [IDX_W-1:0]              idx,
  input  logic                          fixed,
  input  logic                          zero,
  input  logic [NUM_REGS-1:0]           ready_q,
  input  logic [NUM_SET-1:0]            set_eff,
  input  logic [NUM_SET-1:0][IDX_W-1:0] set_idx,
  output logic                          ready,
  output logic                          oor,
  output logic                          zero_bad
);
  localparam int SPAN = 1 << IDX_W;
  logic [SPAN-1:0] padded;
  logic ok, stored, bypass;

  assign padded = SPAN'(ready_q);
  assign ok     = idx_in_range(int'(idx), NUM_REGS);
  assign stored = ok && padded[idx];

  always_comb begin
    bypass = 1'b0;
    for (int s = 0; s < NUM_SET; s++)
      if (set_eff[s] && (set_idx[s] == idx)) bypass = 1'b1;
  end

  assign ready    = fixed || stored || bypass;
  assign oor      = vld && !ok;
  assign zero_bad = vld && ok && !fixed && zero && !padded[idx];
endmodule

// File: rtl/preg_sb_err.sv
module preg_sb_err #(
  parameter int NUM_VIOL = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_VIOL-1:0] viol,
  output logic                err
);
  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= |viol;
  end
endmodule

// File: rtl/preg_ready_board.sv
module preg_ready_board #(
  parameter int NUM_REGS   = 96,
  parameter int NUM_LOOKUP = 2,
  parameter int NUM_SET    = 2,
  parameter int NUM_CLR    = 1,
  parameter int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_LOOKUP-1:0]            lk_vld,
  input  logic [NUM_LOOKUP-1:0][IDX_W-1:0] lk_idx,
  input  logic [NUM_LOOKUP-1:0]            lk_fixed,
  input  logic [NUM_LOOKUP-1:0]            lk_zero,
  output logic [NUM_LOOKUP-1:0]            lk_ready,
  input  logic [NUM_SET-1:0]               set_vld,
  input  logic [NUM_SET-1:0][IDX_W-1:0]    set_idx,
  input  logic [NUM_SET-1:0]               set_fixed,
  input  logic [NUM_CLR-1:0]               clr_vld,
  input  logic [NUM_CLR-1:0][IDX_W-1:0]    clr_idx,
  input  logic [NUM_CLR-1:0]               clr_fixed,
  input  logic [NUM_CLR-1:0]               clr_zero,
  output logic                             err
);
  localparam int NUM_VIOL = 2 * NUM_LOOKUP + NUM_SET + NUM_CLR;

  logic [NUM_REGS-1:0]   ready_q;
  logic [NUM_SET-1:0]    set_eff, set_oor;
  logic [NUM_CLR-1:0]    clr_eff, clr_oor;
  logic [NUM_LOOKUP-1:0] lk_oor, lk_zero_bad;
  logic [NUM_VIOL-1:0]   viol;

  preg_sb_qual #(.NUM_REGS(NUM_REGS), .NUM_SET(NUM_SET), .NUM_CLR(NUM_CLR), .IDX_W(IDX_W)) u_qual (
    .set_vld(set_vld), .set_idx(set_idx), .set_fixed(set_fixed),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_fixed(clr_fixed), .clr_zero(clr_zero),
    .set_eff(set_eff), .clr_eff(clr_eff), .set_oor(set_oor), .clr_oor(clr_oor)
  );

  preg_sb_array #(.NUM_REGS(NUM_REGS), .NUM_SET(NUM_SET), .NUM_CLR(NUM_CLR), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst(rst), .set_eff(set_eff), .set_idx(set_idx),
    .clr_eff(clr_eff), .clr_idx(clr_idx), .ready_q(ready_q)
  );

  for (genvar p = 0; p < NUM_LOOKUP; p++) begin : g_lk
    preg_sb_lookup #(.NUM_REGS(NUM_REGS), .NUM_SET(NUM_SET), .IDX_W(IDX_W)) u_lk (
      .vld(lk_vld[p]), .idx(lk_idx[p]), .fixed(lk_fixed[p]), .zero(lk_zero[p]),
      .ready_q(ready_q), .set_eff(set_eff), .set_idx(set_idx),
      .ready(lk_ready[p]), .oor(lk_oor[p]), .zero_bad(lk_zero_bad[p])
    );
  end

  assign viol = {lk_zero_bad, lk_oor, set_oor, clr_oor};

  preg_sb_err #(.NUM_VIOL(NUM_VIOL)) u_err (
    .clk(clk), .rst(rst), .viol(viol), .err(err)
  );
endmodule

// File: rtl/preg_ready_board_chk.sv
module preg_ready_board_chk #(
  parameter int NUM_REGS   = 96,
  parameter int NUM_LOOKUP = 2,
  parameter int NUM_SET    = 2,
  parameter int NUM_CLR    = 1,
  parameter int IDX_W      = $clog2(NUM_REGS)
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_LOOKUP-1:0]            lk_vld,
  input logic [NUM_LOOKUP-1:0][IDX_W-1:0] lk_idx,
  input logic [NUM_LOOKUP-1:0]            lk_fixed,
  input logic [NUM_LOOKUP-1:0]            lk_zero,
  input logic [NUM_LOOKUP-1:0]            lk_ready,
  input logic [NUM_SET-1:0]               set_vld,
  input logic [NUM_SET-1:0][IDX_W-1:0]    set_idx,
  input logic [NUM_SET-1:0]               set_fixed,
  input logic [NUM_CLR-1:0]               clr_vld,
  input logic [NUM_CLR-1:0][IDX_W-1:0]    clr_idx,
  input logic [NUM_CLR-1:0]               clr_fixed,
  input logic [NUM_CLR-1:0]               clr_zero,
  input logic                             err,
  input logic [NUM_REGS-1:0]              ready_q,
  input logic [NUM_SET-1:0]               set_eff,
  input logic [NUM_CLR-1:0]               clr_eff
);
  localparam int SPAN = 1 << IDX_W;
  logic [SPAN-1:0] pad;
  logic any_oor, any_zero_bad, no_write;

  assign pad = SPAN'(ready_q);

  always_comb begin
    any_oor = 1'b0;
    any_zero_bad = 1'b0;
    no_write = 1'b1;
    for (int p = 0; p < NUM_LOOKUP; p++) begin
      if (lk_vld[p] && int'(lk_idx[p]) >= NUM_REGS) any_oor = 1'b1;
      if (lk_vld[p] && int'(lk_idx[p]) < NUM_REGS && !lk_fixed[p] && lk_zero[p] && !pad[lk_idx[p]])
        any_zero_bad = 1'b1;
    end
    for (int s = 0; s < NUM_SET; s++) begin
      if (set_vld[s] && int'(set_idx[s]) >= NUM_REGS) any_oor = 1'b1;
      if (set_vld[s] && !set_fixed[s]) no_write = 1'b0;
    end
    for (int c = 0; c < NUM_CLR; c++) begin
      if (clr_vld[c] && int'(clr_idx[c]) >= NUM_REGS) any_oor = 1'b1;
      if (clr_vld[c] && !clr_fixed[c]) no_write = 1'b0;
    end
  end

  p_reset_all_ready_r1: assert property (@(posedge clk) rst |=> (&ready_q));

  p_fixed_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    no_write |=> $stable(ready_q));

  p_err_on_oor_r8: assert property (@(posedge clk) disable iff (rst)
    any_oor |=> err);

  p_err_on_zero_bad_r9: assert property (@(posedge clk) disable iff (rst)
    any_zero_bad |=> err);

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!any_oor && !any_zero_bad) |=> !err);

  for (genvar s = 0; s < NUM_SET; s++) begin : g_set_chk
    p_set_takes_r2: assert property (@(posedge clk) disable iff (rst)
      set_eff[s] |=> pad[$past(set_idx[s])]);
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (set_eff[s] && clr_vld[0] && clr_idx[0] == set_idx[s]) |=> pad[$past(set_idx[s])]);
  end

  p_zero_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_vld[0] && clr_zero[0] && !(|clr_eff) && int'(clr_idx[0]) < NUM_REGS && pad[clr_idx[0]])
      |=> pad[$past(clr_idx[0])]);

  for (genvar p = 0; p < NUM_LOOKUP; p++) begin : g_lk_chk
    p_fixed_reads_ready_r3: assert property (@(posedge clk) disable iff (rst)
      lk_fixed[p] |-> lk_ready[p]);
    for (genvar s = 0; s < NUM_SET; s++) begin : g_byp
      p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        (set_eff[s] && lk_idx[p] == set_idx[s]) |-> lk_ready[p]);
    end
  end
endmodule

bind preg_ready_board preg_ready_board_chk #(
  .NUM_REGS(NUM_REGS), .NUM_LOOKUP(NUM_LOOKUP), .NUM_SET(NUM_SET),
  .NUM_CLR(NUM_CLR), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_vld(lk_vld), .lk_idx(lk_idx), .lk_fixed(lk_fixed),
  .lk_zero(lk_zero), .lk_ready(lk_ready), .set_vld(set_vld), .set_idx(set_idx),
  .set_fixed(set_fixed), .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_fixed(clr_fixed),
  .clr_zero(clr_zero), .err(err), .ready_q(ready_q), .set_eff(set_eff), .clr_eff(clr_eff)
);

// File: tb/sim_preg_ready_board.sv
module sim_preg_ready_board;
  localparam int N  = 96;
  localparam int NL = 2;
  localparam int NS = 2;
  localparam int NC = 1;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0]         lk_vld = '0, lk_fixed = '0, lk_zero = '0, lk_ready;
  logic [NL-1:0][IW-1:0] lk_idx = '0;
  logic [NS-1:0]         set_vld = '0, set_fixed = '0;
  logic [NS-1:0][IW-1:0] set_idx = '0;
  logic [NC-1:0]         clr_vld = '0, clr_fixed = '0, clr_zero = '0;
  logic [NC-1:0][IW-1:0] clr_idx = '0;
  logic err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [N-1:0] model;

  always #2 clk = ~clk;

  preg_ready_board #(.NUM_REGS(N), .NUM_LOOKUP(NL), .NUM_SET(NS), .NUM_CLR(NC)) u0 (
    .clk(clk), .rst(rst), .lk_vld(lk_vld), .lk_idx(lk_idx), .lk_fixed(lk_fixed),
    .lk_zero(lk_zero), .lk_ready(lk_ready), .set_vld(set_vld), .set_idx(set_idx),
    .set_fixed(set_fixed), .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_fixed(clr_fixed),
    .clr_zero(clr_zero), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected combinational answer of lookup port p.
  function automatic bit exp_lookup(input int p);
    int i = int'(lk_idx[p]);
    if (lk_fixed[p]) return 1;
    if (i >= N) return 0;
    for (int s = 0; s < NS; s++)
      if (set_vld[s] && !set_fixed[s] && int'(set_idx[s]) == i) return 1;
    return model[i];
  endfunction

  function automatic bit exp_violation();
    bit v = 0;
    for (int p = 0; p < NL; p++) begin
      if (lk_vld[p] && int'(lk_idx[p]) >= N) v = 1;
      else if (lk_vld[p] && !lk_fixed[p] && lk_zero[p] && !model[int'(lk_idx[p])]) v = 1;
    end
    for (int s = 0; s < NS; s++) if (set_vld[s] && int'(set_idx[s]) >= N) v = 1;
    for (int c = 0; c < NC; c++) if (clr_vld[c] && int'(clr_idx[c]) >= N) v = 1;
    return v;
  endfunction

  // Model update: clears first, then sets overwrite them.
  function automatic logic [N-1:0] next_model();
    logic [N-1:0] m = model;
    for (int c = 0; c < NC; c++)
      if (clr_vld[c] && !clr_fixed[c] && !clr_zero[c] && int'(clr_idx[c]) < N) m[int'(clr_idx[c])] = 1'b0;
    for (int s = 0; s < NS; s++)
      if (set_vld[s] && !set_fixed[s] && int'(set_idx[s]) < N) m[int'(set_idx[s])] = 1'b1;
    return m;
  endfunction

  // Called just after a falling edge with inputs already driven.
  task automatic run_cycle(input string why);
    bit nerr;
    logic [N-1:0] nxt;
    #1;
    for (int p = 0; p < NL; p++) begin
      if (lk_vld[p]) begin
        string tag;
        bit e = exp_lookup(p);
        tag = lk_fixed[p] ? "R3" : (int'(lk_idx[p]) >= N) ? "R8" : "R2/R7/R11";
        chk(lk_ready[p] === e, {why, " lookup ", tag}, int'(lk_ready[p]), int'(e));
      end
    end
    nerr = exp_violation();
    nxt  = next_model();
    @(posedge clk);
    model = nxt;
    @(negedge clk);
    chk(err === nerr, {why, nerr ? " err R8/R9" : " err R10"}, int'(err), int'(nerr));
  endtask

  task automatic idle();
    lk_vld = '0; lk_fixed = '0; lk_zero = '0; lk_idx = '0;
    set_vld = '0; set_fixed = '0; set_idx = '0;
    clr_vld = '0; clr_fixed = '0; clr_zero = '0; clr_idx = '0;
  endtask

  task automatic look(input int p, input int i, input bit fx, input bit zr);
    lk_vld[p] = 1'b1; lk_idx[p] = IW'(i); lk_fixed[p] = fx; lk_zero[p] = zr;
  endtask

  function automatic int rand_idx();
    if ($urandom % 16 == 0) return N + int'($urandom % (32'(1 << IW) - N));
    return int'($urandom % 20);
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    model = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(err === 1'b0, "R1 err after reset", int'(err), 0);

    // R1: every register reads ready after reset.
    for (int i = 0; i < N; i += 2) begin
      idle(); look(0, i, 0, 0); look(1, i + 1, 0, 0);
      run_cycle("R1 scan");
    end

    // R2: plain clear, then set.
    idle(); clr_vld[0] = 1; clr_idx[0] = 3; run_cycle("R2 clear");
    idle(); look(0, 3, 0, 0); run_cycle("R2 cleared");
    chk(model[3] == 1'b0, "R2 model", int'(model[3]), 0);
    idle(); set_vld[1] = 1; set_idx[1] = 3; run_cycle("R2 set");
    idle(); look(1, 3, 0, 0); run_cycle("R2 set seen");

    // R5: clear tagged zero is dropped.
    idle(); clr_vld[0] = 1; clr_idx[0] = 0; clr_zero[0] = 1; run_cycle("R5 zero clear");
    idle(); look(0, 0, 0, 1); run_cycle("R5 zero still ready");
    chk(lk_ready[0] === 1'b1, "R5 lookup", int'(lk_ready[0]), 1);

    // R4: fixed clear and fixed set are dropped.
    idle(); clr_vld[0] = 1; clr_idx[0] = 6; clr_fixed[0] = 1; run_cycle("R4 fixed clear");
    idle(); look(0, 6, 0, 0); #1;
    chk(lk_ready[0] === 1'b1, "R4 after fixed clear", int'(lk_ready[0]), 1);
    run_cycle("R4");
    idle(); clr_vld[0] = 1; clr_idx[0] = 6; run_cycle("R4 prep");
    idle(); set_vld[0] = 1; set_idx[0] = 6; set_fixed[0] = 1; run_cycle("R4 fixed set");
    idle(); look(1, 6, 0, 0); #1;
    chk(lk_ready[1] === 1'b0, "R4 after fixed set", int'(lk_ready[1]), 0);
    run_cycle("R4");

    // R3: fixed lookup of a not-ready and an out-of-range index.
    idle(); look(0, 6, 1, 0); look(1, 120, 1, 0); run_cycle("R3 fixed");

    // R6: set and clear on one index.
    idle(); set_vld[1] = 1; set_idx[1] = 6; clr_vld[0] = 1; clr_idx[0] = 6; run_cycle("R6 collide");
    idle(); look(0, 6, 0, 0); #1;
    chk(lk_ready[0] === 1'b1, "R6 set wins", int'(lk_ready[0]), 1);
    run_cycle("R6");

    // R7: bypass of a same-cycle set.
    idle(); clr_vld[0] = 1; clr_idx[0] = 9; run_cycle("R7 prep");
    idle(); set_vld[0] = 1; set_idx[0] = 9; look(1, 9, 0, 0); #1;
    chk(lk_ready[1] === 1'b1, "R7 bypass", int'(lk_ready[1]), 1);
    run_cycle("R7");

    // R11: two sets and a clear on different indices at once.
    idle(); clr_vld[0] = 1; clr_idx[0] = 12; run_cycle("R11 prep a");
    idle(); clr_vld[0] = 1; clr_idx[0] = 13; run_cycle("R11 prep b");
    idle(); set_vld = 2'b11; set_idx[0] = 12; set_idx[1] = 13; clr_vld[0] = 1; clr_idx[0] = 14;
    run_cycle("R11 parallel");
    idle(); look(0, 12, 0, 0); look(1, 14, 0, 0); #1;
    chk(lk_ready[0] === 1'b1 && lk_ready[1] === 1'b0, "R11 ports", int'(lk_ready), 1);
    run_cycle("R11");

    // R8: out-of-range requests.
    idle(); look(0, 100, 0, 0); #1;
    chk(lk_ready[0] === 1'b0, "R8 oor lookup", int'(lk_ready[0]), 0);
    run_cycle("R8 lookup");
    chk(err === 1'b1, "R8 err", int'(err), 1);
    idle(); set_vld[0] = 1; set_idx[0] = 127; run_cycle("R8 set");
    idle(); run_cycle("R10 quiet");

    // R9: zero-tagged lookup of a cleared bit.
    idle(); clr_vld[0] = 1; clr_idx[0] = 11; run_cycle("R9 prep");
    idle(); look(1, 11, 0, 1); run_cycle("R9 zero bad");
    chk(err === 1'b1, "R9 err", int'(err), 1);

    // Random traffic with frequent collisions.
    for (int n = 0; n < 3000; n++) begin
      idle();
      for (int p = 0; p < NL; p++) begin
        lk_vld[p] = ($urandom % 4) != 0; lk_idx[p] = IW'(rand_idx());
        lk_fixed[p] = ($urandom % 8) == 0; lk_zero[p] = ($urandom % 8) == 0;
      end
      for (int s = 0; s < NS; s++) begin
        set_vld[s] = ($urandom % 3) == 0; set_idx[s] = IW'(rand_idx());
        set_fixed[s] = ($urandom % 8) == 0;
      end
      for (int c = 0; c < NC; c++) begin
        clr_vld[c] = ($urandom % 2) == 0; clr_idx[c] = IW'(rand_idx());
        clr_fixed[c] = ($urandom % 8) == 0; clr_zero[c] = ($urandom % 8) == 0;
      end
      run_cycle("random");
    end

    // R1: reset mid-run restores all-ready.
    idle(); rst = 1'b1; @(negedge clk); rst = 1'b0; model = '1;
    chk(err === 1'b0, "R1 err after second reset", int'(err), 0);
    idle(); look(0, 11, 0, 0); look(1, 14, 0, 0); run_cycle("R1 rereset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule